// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD. It holds eight fields: seconds, minutes, hours in 24-hour form, weekday, date, month, two-digit year and a century count. A one-second enable pulse advances it. Each field carries into the next one when it wraps. The number of days in each month is applied, and a year divisible by four gets a 29th of February. A 99-to-00 year wrap carries into the century, which has its own upper limit.

A register window outside the block sets the time through a parallel load. The load replaces all eight fields at once and wins over a tick that arrives in the same cycle. A stop input freezes counting while the seconds source is halted. A one-cycle wrap flag for each field marks the tick at which that field returned to its first value.

Field packing on both time buses: field i sits in bits [8*i+7 : 8*i], with i = 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century. Each byte is two BCD digits, with the tens digit in the upper nibble.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time bus reads 64'h0000_0101_0100_0000: century 00, year 00, month 01, date 01, weekday 01, hours 00, minutes 00, seconds 00. All wrap flags are 0.
- R2: A cycle with sec_tick high, osc_stop low and load_en low adds one to seconds, and the result is visible after that clock edge. A cycle with sec_tick low and load_en low leaves every field unchanged.
- R3: Seconds and minutes count 00 to 59 in BCD. On the 59-to-00 wrap the next field up advances by one.
- R4: Hours count 00 to 23. On the 23-to-00 wrap, weekday and date each advance by one.
- R5: Weekday counts 01 to 07 and wraps to 01 at midnight, whatever the date does.
- R6: Months 04, 06, 09 and 11 end after date 30. Months 01, 03, 05, 07, 08, 10 and 12 end after date 31. After the last date the date goes to 01 and the month advances.
- R7: February ends after date 29 when the year is divisible by four, year 00 included. In any other year it ends after date 28.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century. Century wraps from CENT_LAST (default 39) to 00.
- R9: While osc_stop is high, a tick changes no field and raises no wrap flag.
- R10: When load_en is high, the time bus takes load_time at that edge, whatever sec_tick and osc_stop are. No wrap flag is raised in that cycle.
- R11: Bit i of roll_flag is high for exactly the one cycle after the tick that wrapped field i. That field then reads its first value: 00, or 01 for weekday, date and month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| osc_stop | input | 1 | High: counting frozen |
| load_en | input | 1 | Parallel load strobe |
| load_time | input | 64 | Eight packed BCD fields to load |
| cur_time | output | 64 | Eight packed BCD fields, current time |
| roll_flag | output | 8 | Per-field wrap flag, one cycle wide |

## Verification
Two functions can land in the same clock cycle: a tick that carries through several fields, and a parallel load. The bench drives load_en together with sec_tick. It does this with loaded values that are themselves on the edge of rolling (23:59:59 on 31 December 99, century 39). The cycle passes only if the loaded value appears unchanged and all wrap flags stay low. The opposite case is also driven: the same edge values are loaded, then a plain tick follows, and all eight fields must wrap together with every flag set. Random stimulus mixes ticks, stops and loads near the field limits. A bench calendar computed in integers judges every cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int NUM_FIELDS = 8;
   localparam int BCD_W      = 8;

   localparam int F_SEC   = 0;
   localparam int F_MIN   = 1;
   localparam int F_HOUR  = 2;
   localparam int F_WDAY  = 3;
   localparam int F_DATE  = 4;
   localparam int F_MONTH = 5;
   localparam int F_YEAR  = 6;
   localparam int F_CENT  = 7;

   // two-digit BCD successor
   function automatic logic [BCD_W-1:0] bcd_succ(input logic [BCD_W-1:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // first value of a field after it wraps
   function automatic logic [BCD_W-1:0] field_first(input int idx);
      if (idx == F_WDAY || idx == F_DATE || idx == F_MONTH) return 8'h01;
      return 8'h00;
   endfunction
endpackage

// File: rtl/cal_month_days.sv
module cal_month_days
   import cal_pkg::*;
(
   input  logic [BCD_W-1:0] month,
   input  logic [BCD_W-1:0] year,
   output logic [BCD_W-1:0] last_date
);
   // 10*t + u is divisible by 4 exactly when 2*t + u is
   logic [1:0] mod4;
   logic       leap;

   assign mod4 = {year[4], 1'b0} + year[1:0];
   assign leap = (mod4 == 2'd0);

   always_comb begin
      unique case (month)
         8'h02:                      last_date = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
         default:                    last_date = 8'h31;
      endcase
   end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
   import cal_pkg::*;
#(
   parameter logic [BCD_W-1:0] FIRST = 8'h00
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BCD_W-1:0] load_val,
   input  logic             inc,
   input  logic [BCD_W-1:0] last,
   output logic [BCD_W-1:0] q,
   output logic             wrap,
   output logic             roll
);
   logic [BCD_W-1:0] q_nxt;

   assign wrap = inc & (q == last);

   always_comb begin
      if (load)      q_nxt = load_val;
      else if (wrap) q_nxt = FIRST;
      else if (inc)  q_nxt = bcd_succ(q);
      else           q_nxt = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q    <= FIRST;
         roll <= 1'b0;
      end else begin
         q    <= q_nxt;
         roll <= wrap & ~load;
      end
   end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import cal_pkg::*;
#(
   parameter logic [BCD_W-1:0] CENT_LAST = 8'h39,
   parameter logic [BCD_W-1:0] WDAY_LAST = 8'h07
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sec_tick,
   input  logic                        osc_stop,
   input  logic                        load_en,
   input  logic [NUM_FIELDS*BCD_W-1:0] load_time,
   output logic [NUM_FIELDS*BCD_W-1:0] cur_time,
   output logic [NUM_FIELDS-1:0]       roll_flag
);
   localparam int TIME_W = NUM_FIELDS * BCD_W;

   if (CENT_LAST[3:0] > 4'd9 || CENT_LAST[7:4] > 4'd9)
      $error("CENT_LAST must be a BCD value");
   if (WDAY_LAST < 8'h02 || WDAY_LAST > 8'h09)
      $error("WDAY_LAST must lie in 02..09");
   if (TIME_W != 64)
      $error("field packing expects eight bytes");

   function automatic logic [BCD_W-1:0] fixed_last(input int idx);
      case (idx)
         F_SEC, F_MIN: return 8'h59;
         F_HOUR:       return 8'h23;
         F_WDAY:       return WDAY_LAST;
         F_MONTH:      return 8'h12;
         F_YEAR:       return 8'h99;
         F_CENT:       return CENT_LAST;
         default:      return 8'h00;
      endcase
   endfunction

   logic [NUM_FIELDS-1:0] inc;
   logic [NUM_FIELDS-1:0] wrap;
   logic [BCD_W-1:0]      month_last;

   // carry chain: weekday and date both hang off the hour wrap
   assign inc[F_SEC]   = sec_tick & ~osc_stop & ~load_en;
   assign inc[F_MIN]   = wrap[F_SEC];
   assign inc[F_HOUR]  = wrap[F_MIN];
   assign inc[F_WDAY]  = wrap[F_HOUR];
   assign inc[F_DATE]  = wrap[F_HOUR];
   assign inc[F_MONTH] = wrap[F_DATE];
   assign inc[F_YEAR]  = wrap[F_MONTH];
   assign inc[F_CENT]  = wrap[F_YEAR];

   cal_month_days u_month_days (
      .month     (cur_time[F_MONTH*BCD_W +: BCD_W]),
      .year      (cur_time[F_YEAR*BCD_W +: BCD_W]),
      .last_date (month_last)
   );

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      logic [BCD_W-1:0] lim;
      if (g == F_DATE) begin : g_var
         assign lim = month_last;
      end else begin : g_fix
         assign lim = fixed_last(g);
      end

      cal_bcd_field #(.FIRST(field_first(g))) u_field (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load_en),
         .load_val (load_time[g*BCD_W +: BCD_W]),
         .inc      (inc[g]),
         .last     (lim),
         .q        (cur_time[g*BCD_W +: BCD_W]),
         .wrap     (wrap[g]),
         .roll     (roll_flag[g])
      );
   end
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        sec_tick,
   input logic        osc_stop,
   input logic        load_en,
   input logic [63:0] load_time,
   input logic [63:0] cur_time,
   input logic [7:0]  roll_flag
);
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> cur_time == $past(load_time));

   a_r10_no_roll_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> roll_flag == 8'h00);

   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stop && !load_en) |=> ($stable(cur_time) && roll_flag == 8'h00));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !load_en) |=> $stable(cur_time));

   a_r3_sec_digits: assert property (@(posedge clk) disable iff (!rst_n)
      cur_time[7:4] <= 4'd5 && cur_time[3:0] <= 4'd9);

   a_r4_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      roll_flag[2] |-> (cur_time[23:16] == 8'h00 && roll_flag[1] && roll_flag[0]));

   a_r5_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      roll_flag[3] |-> (cur_time[31:24] == 8'h01 && roll_flag[2]));

   a_r8_cent_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      roll_flag[7] |-> (cur_time[63:56] == 8'h00 && roll_flag[6]));

   a_r11_sec_roll: assert property (@(posedge clk) disable iff (!rst_n)
      roll_flag[0] |-> cur_time[7:0] == 8'h00);
endmodule

bind bcd_calendar cal_checker i_cal_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .osc_stop  (osc_stop),
   .load_en   (load_en),
   .load_time (load_time),
   .cur_time  (cur_time),
   .roll_flag (roll_flag)
);

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        osc_stop = 1'b0;
   logic        load_en = 1'b0;
   logic [63:0] load_time = '0;
   logic [63:0] cur_time;
   logic [7:0]  roll_flag;

   int n_chk = 0;
   int n_err = 0;

   int          m [8];
   logic [7:0]  e_roll;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_calendar i_bcd_calendar (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_stop(osc_stop),
      .load_en(load_en), .load_time(load_time),
      .cur_time(cur_time), .roll_flag(roll_flag)
   );

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] i2b(input int v);
      logic [3:0] t, u;
      t = 4'(v / 10);
      u = 4'(v % 10);
      return {t, u};
   endfunction

   function automatic int days_in(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [63:0] pack(input int s, input int mi, input int h,
      input int wd, input int d, input int mo, input int y, input int c);
      return {i2b(c), i2b(y), i2b(mo), i2b(d), i2b(wd), i2b(h), i2b(mi), i2b(s)};
   endfunction

   function automatic logic [63:0] expected();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[8*i +: 8] = i2b(m[i]);
      return v;
   endfunction

   task automatic model_step(input bit ld, input logic [63:0] lv, input bit tk, input bit st);
      e_roll = 8'h00;
      if (ld) begin
         for (int i = 0; i < 8; i++) m[i] = b2i(lv[8*i +: 8]);
      end else if (tk && !st) begin
         m[0]++;
         if (m[0] > 59) begin
            m[0] = 0; e_roll[0] = 1'b1; m[1]++;
            if (m[1] > 59) begin
               m[1] = 0; e_roll[1] = 1'b1; m[2]++;
               if (m[2] > 23) begin
                  m[2] = 0; e_roll[2] = 1'b1;
                  m[3]++;
                  if (m[3] > 7) begin m[3] = 1; e_roll[3] = 1'b1; end
                  m[4]++;
                  if (m[4] > days_in(m[5], m[6])) begin
                     m[4] = 1; e_roll[4] = 1'b1; m[5]++;
                     if (m[5] > 12) begin
                        m[5] = 1; e_roll[5] = 1'b1; m[6]++;
                        if (m[6] > 99) begin
                           m[6] = 0; e_roll[6] = 1'b1; m[7]++;
                           if (m[7] > 39) begin m[7] = 0; e_roll[7] = 1'b1; end
                        end
                     end
                  end
               end
            end
         end
      end
   endtask

   task automatic check(input string tag);
      n_chk++;
      if (cur_time !== expected() || roll_flag !== e_roll) begin
         n_err++;
         $display("FAIL %s: time=%h roll=%b expected time=%h roll=%b",
                  tag, cur_time, roll_flag, expected(), e_roll);
      end
   endtask

   // called at a falling edge; drives, clocks, checks at the next falling edge
   task automatic cyc(input bit ld, input logic [63:0] lv, input bit tk, input bit st,
                      input string tag);
      load_en = ld; load_time = lv; sec_tick = tk; osc_stop = st;
      @(posedge clk);
      model_step(ld, lv, tk, st);
      @(negedge clk);
      load_en = 1'b0; sec_tick = 1'b0; osc_stop = 1'b0;
      check(tag);
   endtask

   function automatic int pick(input int lo, input int hi);
      if ($urandom_range(0, 1) == 0) return hi - int'($urandom_range(0, 1));
      return lo + int'($urandom_range(0, hi - lo));
   endfunction

   function automatic logic [63:0] rand_time();
      int s, mi, h, wd, d, mo, y, c;
      s = pick(0, 59); mi = pick(0, 59); h = pick(0, 23); wd = pick(1, 7);
      mo = pick(1, 12); y = pick(0, 99); c = pick(0, 39);
      d = pick(1, days_in(mo, y));
      return pack(s, mi, h, wd, d, mo, y, c);
   endfunction

   initial begin
      void'($urandom(32'd20250));
      m = '{0, 0, 0, 1, 1, 1, 0, 0};
      e_roll = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1");

      cyc(1'b0, '0, 1'b1, 1'b0, "R2");
      cyc(1'b0, '0, 1'b0, 1'b0, "R2");
      cyc(1'b0, '0, 1'b1, 1'b1, "R9");

      // R10: load wins over a tick on an edge-of-rollover value
      cyc(1'b1, pack(59, 59, 23, 7, 31, 12, 99, 39), 1'b1, 1'b0, "R10");
      // R8, R11: full cascade, all fields wrap
      cyc(1'b0, '0, 1'b1, 1'b0, "R8");
      cyc(1'b0, '0, 1'b1, 1'b0, "R11");

      // R3: minute carry only
      cyc(1'b1, pack(59, 14, 5, 2, 3, 3, 10, 20), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b0, "R3");
      // R4 and R5: weekday wraps while date does not
      cyc(1'b1, pack(59, 59, 23, 7, 10, 5, 10, 20), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b0, "R5");
      // R6: 30-day and 31-day months
      cyc(1'b1, pack(59, 59, 23, 1, 30, 4, 11, 20), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b0, "R6");
      cyc(1'b1, pack(59, 59, 23, 1, 30, 1, 11, 20), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b0, "R6");
      // R7: February in leap, non-leap and year 00
      cyc(1'b1, pack(59, 59, 23, 3, 28, 2, 24, 20), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b0, "R7");
      cyc(1'b1, pack(59, 59, 23, 3, 28, 2, 23, 20), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b0, "R7");
      cyc(1'b1, pack(59, 59, 23, 3, 29, 2, 0, 21), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b0, "R7");
      // R9: stopped at an edge value
      cyc(1'b1, pack(59, 59, 23, 7, 31, 12, 99, 39), 1'b0, 1'b0, "R10");
      cyc(1'b0, '0, 1'b1, 1'b1, "R9");

      for (int k = 0; k < 3000; k++) begin
         bit ld, tk, st;
         ld = ($urandom_range(0, 99) < 4);
         tk = ($urandom_range(0, 99) < 75);
         st = ($urandom_range(0, 99) < 10);
         cyc(ld, ld ? rand_time() : 64'h0, tk, st, "R2");
      end

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: time=%h expected completion", cur_time);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule